// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block sits behind a CAN receiver's header parser and decides, for each received frame header, whether the frame is kept and which receive queue it is steered to. The parser presents an 11-bit base identifier, the 18-bit identifier extension, the IDE flag and the RTR flag, together with a one-cycle strobe. The block holds a bank of programmable filters. Each filter is either one identifier/mask pair that covers the whole header, or two independent narrow pairs that see only the base identifier, the two flag bits and the three most significant extension bits.

The bank is walked one filter at a time by a small scan controller, and a single shared comparator is used for every test. The first filter that matches ends the scan. It produces a one-cycle accept pulse that carries the filter number, the half that hit, and the queue number programmed into that filter. If nothing matches, the scan produces a reject pulse. Filters are programmed through a plain write port, and writes take effect only while no header is waiting or being scanned.

Top module: `can_accept_filter`

## Requirements
- R1: A filter in wide mode compares the word {base_id[10:0], ext_id[17:0], ide, rtr, 1'b0} (base_id at bits 31:21, ide at bit 2, rtr at bit 1) against its identifier under its mask. A mask bit of 0 means the bit is ignored, and a match needs every bit with mask 1 to equal the identifier bit.
- R2: A filter in split mode compares the halfword {base_id[10:0], rtr, ide, ext_id[17:15]} (base_id at bits 15:5, rtr at bit 4, ide at bit 3). Its low pair is cfg_id/cfg_mask bits 15:0 and its high pair is bits 31:16. ext_id[14:0] never affects a split-mode decision.
- R3: The two halves of a split filter match independently. The low half is tested before the high half, and out_half reports which one hit (0 = low, 1 = high).
- R4: Filters are tested in ascending index order and the first match wins. out_filt reports its index and out_fifo reports the queue number written with it.
- R5: A filter whose active bit is 0 never matches. Reset clears every active bit.
- R6: Each header produces exactly one result: a one-cycle out_accept or a one-cycle out_reject, never both. out_reject is produced when no active filter matches.
- R7: A header strobed while a scan is in progress is held and scanned after the current result. busy is high from the cycle after a strobe until its result is produced.
- R8: A configuration write issued while busy is high is dropped and changes no filter.
- R9: The result of a header appears no more than 3*NUM_FILT+2 clock cycles after the edge that samples its strobe.
- R10: After reset, busy, out_accept and out_reject are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | One-cycle strobe, header fields valid |
| hdr_stid | input | 11 | Base identifier |
| hdr_exid | input | 18 | Identifier extension |
| hdr_ide | input | 1 | Extended-format flag |
| hdr_rtr | input | 1 | Remote request flag |
| cfg_we | input | 1 | Filter write strobe |
| cfg_idx | input | IDX_W | Filter number to write |
| cfg_active | input | 1 | Filter enable |
| cfg_split | input | 1 | 1 = two narrow pairs, 0 = one wide pair |
| cfg_fifo | input | FIFO_W | Target queue number |
| cfg_id | input | 32 | Identifier bits (two halves in split mode) |
| cfg_mask | input | 32 | Mask bits, 1 = compare |
| busy | output | 1 | Header pending or scan running; writes are dropped |
| out_accept | output | 1 | One-cycle accept pulse |
| out_reject | output | 1 | One-cycle reject pulse |
| out_filt | output | IDX_W | Index of the matching filter |
| out_half | output | 1 | Matching half in split mode |
| out_fifo | output | FIFO_W | Queue of the matching filter |

## Verification
A corrupted scan index or a wrong compare state does not show up as a bad bit pattern. It shows up as the wrong filter number or half on the next accept, or as a reject where an accept was expected. Every such error is visible at the result pulse, at most 3*NUM_FILT+2 cycles after the strobe. A stuck controller shows up as a missing pulse and a busy flag that never drops. A lost pending header shows up as a missing second result. A write that slips through while the block is busy shows up only on a later header, so the tests follow each dropped write with a header that would hit the forbidden filter.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int STID_W = 11;
  localparam int EXID_W = 18;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {SC_IDLE, SC_FETCH, SC_LO, SC_HI} scan_st_e;

  // wide compare word: base id, extension, ide, rtr, fixed zero
  function automatic logic [WORD_W-1:0] pack_full(input logic [STID_W-1:0] stid,
                                                  input logic [EXID_W-1:0] exid,
                                                  input logic ide, input logic rtr);
    return {stid, exid, ide, rtr, 1'b0};
  endfunction

  // narrow compare halfword: base id, rtr, ide, top three extension bits
  function automatic logic [HALF_W-1:0] pack_half(input logic [STID_W-1:0] stid,
                                                  input logic [2:0] ext_top,
                                                  input logic ide, input logic rtr);
    return {stid, rtr, ide, ext_top};
  endfunction
endpackage

// File: rtl/filt_store.sv
module filt_store #(
  parameter int N  = 14,
  parameter int DW = 66,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          wact,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [N-1:0]  act_vec
);
  logic [DW-1:0] mem [N];

  // plain synchronous write / registered read, RAM inferable
  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < N)) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) act_vec <= '0;
    else if (we && (int'(waddr) < N)) act_vec[waddr] <= wact;
  end
endmodule

// File: rtl/filt_cmp.sv
module filt_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] id,
  input  logic [W-1:0] mask,
  output logic         hit
);
  assign hit = ~|((word ^ id) & mask);
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import can_filt_pkg::*;
#(
  parameter int N  = 14,
  parameter int AW = 4,
  parameter int FW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic [WORD_W-1:0] hdr_full,
  input  logic [HALF_W-1:0] hdr_half,
  output logic [AW-1:0]     rd_addr,
  input  logic              ent_act,
  input  logic              ent_split,
  input  logic [FW-1:0]     ent_fifo,
  input  logic [WORD_W-1:0] ent_id,
  input  logic [WORD_W-1:0] ent_mask,
  output logic [WORD_W-1:0] cmp_word,
  output logic [WORD_W-1:0] cmp_id,
  output logic [WORD_W-1:0] cmp_mask,
  input  logic              cmp_hit,
  output logic              busy,
  output logic              out_accept,
  output logic              out_reject,
  output logic [AW-1:0]     out_filt,
  output logic              out_half,
  output logic [FW-1:0]     out_fifo
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  scan_st_e          state;
  logic [AW-1:0]     idx;
  logic              pend_v;
  logic [WORD_W-1:0] pend_full, cur_full;
  logic [HALF_W-1:0] pend_half, cur_half;
  logic              go_acc, go_next;

  assign rd_addr = idx;
  assign busy    = (state != SC_IDLE) || pend_v;

  // operand steering for the single shared comparator
  always_comb begin
    if (state == SC_HI) begin
      cmp_word = {{HALF_W{1'b0}}, cur_half};
      cmp_id   = {{HALF_W{1'b0}}, ent_id[WORD_W-1:HALF_W]};
      cmp_mask = {{HALF_W{1'b0}}, ent_mask[WORD_W-1:HALF_W]};
    end else if (ent_split) begin
      cmp_word = {{HALF_W{1'b0}}, cur_half};
      cmp_id   = {{HALF_W{1'b0}}, ent_id[HALF_W-1:0]};
      cmp_mask = {{HALF_W{1'b0}}, ent_mask[HALF_W-1:0]};
    end else begin
      cmp_word = cur_full;
      cmp_id   = ent_id;
      cmp_mask = ent_mask;
    end
  end

  assign go_acc  = ((state == SC_LO) && ent_act && cmp_hit) || ((state == SC_HI) && cmp_hit);
  assign go_next = ((state == SC_LO) && (!ent_act || (!cmp_hit && !ent_split))) ||
                   ((state == SC_HI) && !cmp_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SC_IDLE;
      idx        <= '0;
      pend_v     <= 1'b0;
      pend_full  <= '0;
      pend_half  <= '0;
      cur_full   <= '0;
      cur_half   <= '0;
      out_accept <= 1'b0;
      out_reject <= 1'b0;
      out_filt   <= '0;
      out_half   <= 1'b0;
      out_fifo   <= '0;
    end else begin
      out_accept <= 1'b0;
      out_reject <= 1'b0;
      if (hdr_valid) begin
        pend_v    <= 1'b1;
        pend_full <= hdr_full;
        pend_half <= hdr_half;
      end else if ((state == SC_IDLE) && pend_v) begin
        pend_v <= 1'b0;
      end
      case (state)
        SC_IDLE: if (pend_v) begin
          cur_full <= pend_full;
          cur_half <= pend_half;
          idx      <= '0;
          state    <= SC_FETCH;
        end
        SC_FETCH: state <= SC_LO;
        default: begin
          if (go_acc) begin
            out_accept <= 1'b1;
            out_filt   <= idx;
            out_half   <= (state == SC_HI);
            out_fifo   <= ent_fifo;
            state      <= SC_IDLE;
          end else if (go_next) begin
            if (idx == LAST) begin
              out_reject <= 1'b1;
              state      <= SC_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= SC_FETCH;
            end
          end else begin
            state <= SC_HI;
          end
        end
      endcase
    end
  end

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_accept, out_reject}));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (out_accept || out_reject) |=> !(out_accept || out_reject));
  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> busy);
  assert_high_half_split_R3: assert property (@(posedge clk) disable iff (rst)
    (state == SC_HI) |-> ent_split);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_FILT = 14,
  parameter int NUM_FIFO = 2,
  localparam int IDX_W  = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
  localparam int FIFO_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic [10:0]       hdr_stid,
  input  logic [17:0]       hdr_exid,
  input  logic              hdr_ide,
  input  logic              hdr_rtr,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_active,
  input  logic              cfg_split,
  input  logic [FIFO_W-1:0] cfg_fifo,
  input  logic [31:0]       cfg_id,
  input  logic [31:0]       cfg_mask,
  output logic              busy,
  output logic              out_accept,
  output logic              out_reject,
  output logic [IDX_W-1:0]  out_filt,
  output logic              out_half,
  output logic [FIFO_W-1:0] out_fifo
);
  localparam int ENT_W = 1 + FIFO_W + 2 * WORD_W;

  logic [ENT_W-1:0]    ent;
  logic [NUM_FILT-1:0] act_vec;
  logic [IDX_W-1:0]    rd_addr;
  logic [WORD_W-1:0]   cmp_word, cmp_id, cmp_mask;
  logic                cmp_hit;
  logic                wr_ok;

  assign wr_ok = cfg_we && !busy;

  filt_store #(.N(NUM_FILT), .DW(ENT_W), .AW(IDX_W)) store_i (
    .clk(clk), .rst(rst), .we(wr_ok), .waddr(cfg_idx),
    .wdata({cfg_split, cfg_fifo, cfg_id, cfg_mask}), .wact(cfg_active),
    .raddr(rd_addr), .rdata(ent), .act_vec(act_vec));

  filt_cmp #(.W(WORD_W)) cmp_i (
    .word(cmp_word), .id(cmp_id), .mask(cmp_mask), .hit(cmp_hit));

  scan_ctrl #(.N(NUM_FILT), .AW(IDX_W), .FW(FIFO_W)) scan_i (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
    .hdr_full(pack_full(hdr_stid, hdr_exid, hdr_ide, hdr_rtr)),
    .hdr_half(pack_half(hdr_stid, hdr_exid[17:15], hdr_ide, hdr_rtr)),
    .rd_addr(rd_addr), .ent_act(act_vec[rd_addr]),
    .ent_split(ent[ENT_W-1]), .ent_fifo(ent[ENT_W-2 -: FIFO_W]),
    .ent_id(ent[2*WORD_W-1:WORD_W]), .ent_mask(ent[WORD_W-1:0]),
    .cmp_word(cmp_word), .cmp_id(cmp_id), .cmp_mask(cmp_mask), .cmp_hit(cmp_hit),
    .busy(busy), .out_accept(out_accept), .out_reject(out_reject),
    .out_filt(out_filt), .out_half(out_half), .out_fifo(out_fifo));

  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(act_vec));
  assert_hit_is_active_R5: assert property (@(posedge clk) disable iff (rst)
    out_accept |-> act_vec[out_filt]);
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
  localparam int N = 14;
  localparam int MAXC = 3 * N + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 1'b0;
  logic [10:0] hdr_stid = '0;
  logic [17:0] hdr_exid = '0;
  logic hdr_ide = 1'b0, hdr_rtr = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic cfg_active = 1'b0, cfg_split = 1'b0;
  logic [0:0] cfg_fifo = '0;
  logic [31:0] cfg_id = '0, cfg_mask = '0;
  logic busy, out_accept, out_reject, out_half;
  logic [3:0] out_filt;
  logic [0:0] out_fifo;

  int n_chk = 0;
  int n_bad = 0;
  logic r_acc, r_rej;
  int r_cyc;

  always #5 clk = ~clk;

  can_accept_filter dut_i (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_stid(hdr_stid),
    .hdr_exid(hdr_exid), .hdr_ide(hdr_ide), .hdr_rtr(hdr_rtr),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_active(cfg_active),
    .cfg_split(cfg_split), .cfg_fifo(cfg_fifo), .cfg_id(cfg_id),
    .cfg_mask(cfg_mask), .busy(busy), .out_accept(out_accept),
    .out_reject(out_reject), .out_filt(out_filt), .out_half(out_half),
    .out_fifo(out_fifo));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_filt(input int idx, input logic act, input logic split,
                            input logic fifo, input logic [31:0] id,
                            input logic [31:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_active = act; cfg_split = split;
    cfg_fifo = fifo; cfg_id = id; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_hdr(input logic [10:0] stid, input logic [17:0] exid,
                          input logic ide, input logic rtr);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_stid = stid; hdr_exid = exid; hdr_ide = ide; hdr_rtr = rtr;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  // waits for the result pulse; counts edges after the strobe edge
  task automatic wait_res(input string req);
    r_acc = 1'b0; r_rej = 1'b0; r_cyc = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      r_cyc++;
      if (out_accept || out_reject) begin
        r_acc = out_accept; r_rej = out_reject;
        break;
      end
    end
    check(req, "result seen", {31'b0, r_acc | r_rej}, 32'd1);
    check("R6", "accept/reject exclusive", {31'b0, r_acc & r_rej}, 32'd0);
  endtask

  task automatic expect_acc(input string req, input int filt, input logic half,
                            input logic fifo);
    wait_res(req);
    check(req, "accept", {31'b0, r_acc}, 32'd1);
    check(req, "filter index", {28'b0, out_filt}, 32'(filt));
    check(req, "half", {31'b0, out_half}, {31'b0, half});
    check(req, "fifo", {31'b0, out_fifo}, {31'b0, fifo});
    @(posedge clk); #1;
    check("R6", "pulse one cycle", {30'b0, out_accept, out_reject}, 32'd0);
  endtask

  task automatic expect_rej(input string req);
    wait_res(req);
    check(req, "reject", {31'b0, r_rej}, 32'd1);
    check("R9", "scan cycles in bound", {31'b0, r_cyc <= MAXC}, 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R10", "busy after reset", {31'b0, busy}, 32'd0);
    check("R10", "pulses after reset", {30'b0, out_accept, out_reject}, 32'd0);
    send_hdr(11'h000, 18'h0, 1'b0, 1'b0);  // all filters inactive: R5
    expect_rej("R5");
  endtask

  // base id 10 + address 101101 + 1 + two ignored bits, ide must be 0
  task automatic t_addr_group();
    logic [10:0] base;
    base = {2'b10, 6'b101101, 1'b1, 2'b00};
    write_filt(3, 1'b1, 1'b0, 1'b1, {base, 18'h0, 3'b000},
               {11'b111_1111_1100, 18'h0, 3'b100});
    for (int k = 0; k < 4; k++) begin
      send_hdr({base[10:2], 2'(k)}, 18'h15A5A, 1'b0, k[0]);
      expect_acc("R1", 3, 1'b0, 1'b1);
    end
    send_hdr({base[10:2], 2'b01}, 18'h0, 1'b1, 1'b0);
    expect_rej("R1");
    send_hdr({2'b10, 6'b101101, 1'b0, 2'b11}, 18'h0, 1'b0, 1'b0);
    expect_rej("R1");
    send_hdr({2'b10, 6'b101100, 1'b1, 2'b11}, 18'h0, 1'b0, 1'b0);
    expect_rej("R1");
  endtask

  task automatic t_full_ext();
    write_filt(5, 1'b1, 1'b0, 1'b0, {11'h2F0, 18'h2A5A5, 1'b1, 1'b0, 1'b0},
               32'hFFFF_FFFF);
    send_hdr(11'h2F0, 18'h2A5A5, 1'b1, 1'b0);
    expect_acc("R1", 5, 1'b0, 1'b0);
    send_hdr(11'h2F0, 18'h2A5A4, 1'b1, 1'b0);
    expect_rej("R1");
  endtask

  task automatic t_split();
    // low: 0x123, rtr 0, ide 0, ext top 000, all cared; high: 0x456 base only
    write_filt(7, 1'b1, 1'b1, 1'b1, {11'h456, 5'b0, 11'h123, 5'b0},
               {16'hFFE0, 16'hFFFF});
    send_hdr(11'h456, 18'h3FFFF, 1'b1, 1'b1);
    expect_acc("R3", 7, 1'b1, 1'b1);
    send_hdr(11'h123, 18'h07FFF, 1'b0, 1'b0);  // low ext bits ignored
    expect_acc("R2", 7, 1'b0, 1'b1);
    send_hdr(11'h123, 18'h08000, 1'b0, 1'b0);  // ext bit 15 differs
    expect_rej("R2");
  endtask

  task automatic t_hold();
    send_hdr(11'h2F0, 18'h2A5A5, 1'b1, 1'b0);
    check("R7", "busy while pending", {31'b0, busy}, 32'd1);
    // second header and a catch-all write, both while busy
    hdr_valid = 1'b1; hdr_stid = 11'h456; hdr_exid = 18'h0; hdr_ide = 1'b0; hdr_rtr = 1'b0;
    cfg_we = 1'b1; cfg_idx = 4'd13; cfg_active = 1'b1; cfg_split = 1'b0;
    cfg_fifo = 1'b1; cfg_id = '0; cfg_mask = '0;
    @(negedge clk);
    hdr_valid = 1'b0; cfg_we = 1'b0;
    expect_acc("R7", 5, 1'b0, 1'b0);
    expect_acc("R7", 7, 1'b1, 1'b1);
    send_hdr(11'h001, 18'h0, 1'b0, 1'b0);
    expect_rej("R8");
  endtask

  task automatic t_priority();
    write_filt(0, 1'b1, 1'b1, 1'b0, {11'h300, 5'b0, 11'h300, 5'b0},
               {16'hFFE0, 16'hFFE0});
    write_filt(1, 1'b1, 1'b0, 1'b1, {11'h300, 21'h0}, {11'h7FF, 21'h0});
    write_filt(9, 1'b1, 1'b0, 1'b0, {11'h300, 21'h0}, {11'h7FF, 21'h0});
    send_hdr(11'h300, 18'h1, 1'b0, 1'b0);
    expect_acc("R3", 0, 1'b0, 1'b0);
    write_filt(0, 1'b0, 1'b1, 1'b0, {11'h300, 5'b0, 11'h300, 5'b0},
               {16'hFFE0, 16'hFFE0});
    send_hdr(11'h300, 18'h1, 1'b0, 1'b0);
    expect_acc("R4", 1, 1'b0, 1'b1);
    write_filt(1, 1'b0, 1'b0, 1'b1, {11'h300, 21'h0}, {11'h7FF, 21'h0});
    send_hdr(11'h300, 18'h1, 1'b0, 1'b0);
    expect_acc("R5", 9, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_addr_group();
    t_full_ext();
    t_split();
    t_hold();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule